// File: doc/BRIEF.md
# Periodic Tick Down-Counter

A 24-bit periodic down-counter for a processor subsystem. Software sets a reload value, picks a count source and turns the counter on. The count source is either every core clock cycle or a one-cycle reference strobe that is already synchronous to the core clock. The counter steps down once per active step. On the step after it reaches zero it reloads and keeps running, so the period is the reload value plus one step.

Each transition from 1 to 0 sets a sticky flag. Reading the control register clears that flag, and so does any write to the current-value register. When interrupt pending is enabled, the same transition also sends a one-cycle pend request to the exception logic. A write to the current-value register forces the count to zero and never causes a pend request.

Access is through a simple single-cycle register port. Read data is registered and appears in the cycle after the read strobe.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous active-low reset, the control, reload and current-value registers all read 0, and `tick_pend` is low.
- R2: The control register is at offset 0x10. Bit 0 is run, bit 1 is pend enable, bit 2 is source select (1 = core clock, 0 = reference strobe). These three bits read back as written. Writes to every other bit, bit 16 included, have no effect, and every other bit except bit 16 reads 0.
- R3: The reload register is at offset 0x14 and the current-value register at 0x18. Both hold 24 bits in bits 23:0, and bits 31:24 always read 0.
- R4: With run set and the core clock selected, the count drops by one on every cycle. With run clear, the count holds.
- R5: With run set and the reference strobe selected, the count changes only on cycles where `ref_tick` is high.
- R6: A step taken while the count is 0 loads the reload value, and counting continues periodically.
- R7: A step from 1 to 0 sets the count flag, which reads as bit 16 of the control register.
- R8: A read of the control register returns the flag and then clears it. If a new 1-to-0 step happens in the same cycle as the read, the flag stays set.
- R9: A write of any value to the current-value register sets the count to 0 and clears the count flag. In that cycle no step is taken and no pend request is raised.
- R10: `tick_pend` is high for exactly one cycle, the cycle in which the count first reads 0 after a 1-to-0 step, and only if pend enable was set. With pend enable clear, it stays low.
- R11: With reload 0, the counter stays at 0 and gives no flag and no pend events.
- R12: `bus_rdata` carries the addressed register in the cycle after `bus_rd`. It is 0 for unmapped offsets and 0 in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ref_tick | input | 1 | Reference count strobe, synchronous to clk |
| tick_pend | output | 1 | One-cycle pend request |

## Verification
A behavioural model in the bench is compared with the outputs on every cycle, under several stimulus patterns:
- Free running on the core clock at short reloads. This tests the decrement and the reload wrap.
- Strobed counting on the reference source with gaps between strobes. This shows whether the source select gates the steps.
- Control reads on every cycle at reload 1. This exposes the ordering between setting the flag and clearing it on a read.
- Back-to-back writes to the current value while running, and a zero reload. These separate a forced clear, and a parked counter, from a real wrap, because neither of them may raise the flag or a pend request.

// File: rtl/tick_pkg.sv
// Shared constants for the tick timer: register offsets and control bit positions.
// Assumes byte offsets fit in the address width chosen at the top.
package tick_pkg;
    localparam int unsigned OFS_CTRL  = 32'h10;
    localparam int unsigned OFS_RLD   = 32'h14;
    localparam int unsigned OFS_CUR   = 32'h18;
    localparam int unsigned BIT_RUN   = 0;
    localparam int unsigned BIT_PEND  = 1;
    localparam int unsigned BIT_CORE  = 2;
    localparam int unsigned BIT_FLAG  = 16;
endpackage

// File: rtl/tick_src_sel.sv
// Count source selection: produces the per-cycle step enable.
// With SYNC_STAGES = 0 the reference input is assumed to be a one-cycle strobe
// already synchronous to clk; otherwise it is treated as a raw slow clock that is
// synchronised and edge-detected here.
module tick_src_sel #(
    parameter int unsigned SYNC_STAGES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic core_sel_i,
    input  logic ref_i,
    output logic step_o
);
    logic ref_step;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign ref_step = ref_i;
        end else begin : g_sync
            logic [SYNC_STAGES:0] sync_q;
            // Shift the raw reference through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-1:0], ref_i};
            end
            assign ref_step = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
        end
    endgenerate

    // Step when running, on every cycle or only on reference strobes.
    always_comb begin
        step_o = run_i & (core_sel_i | ref_step);
    end

    AST_STEP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> run_i); // R4
    AST_CORE_ALWAYS_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && core_sel_i) |-> step_o); // R4
endmodule

// File: rtl/tick_counter.sv
// Down-counter with reload at zero, forced clear, and the registered pend pulse.
// Assumes clear_i and step_i may coincide; the clear wins and suppresses the step.
module tick_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             clear_i,
    input  logic             ien_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o,
    output logic             pend_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic             pend_q;

    // Count down, reload at zero, or clear on a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= '0;
        else if (clear_i)    count_q <= '0;
        else if (step_i) begin
            if (count_q == '0) count_q <= reload_i;
            else               count_q <= count_q - ONE;
        end
    end

    // A step from one to zero is the wrap event.
    always_comb begin
        hit_o = step_i & ~clear_i & (count_q == ONE);
    end

    // Register the pend request so it lines up with the zero count.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= hit_o & ien_i;
    end

    assign count_o = count_q;
    assign pend_o  = pend_q;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_q == '0)); // R9
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && count_q != '0) |=> (count_q == $past(count_q) - ONE)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clear_i) |=> $stable(count_q)); // R4
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && count_q == '0) |=> (count_q == $past(reload_i))); // R6
    AST_PEND_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (count_q == '0)); // R10
    AST_PEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> !pend_q); // R10
    AST_PARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && reload_i == '0) |=> (count_q == '0)); // R11
endmodule

// File: rtl/tick_regs.sv
// Register port: control bits, reload value, sticky count flag and registered read mux.
// Assumes single-cycle read and write strobes; reads see state before the same edge.
module tick_regs
    import tick_pkg::*;
#(
    parameter int unsigned CNT_W = 24,
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [CNT_W-1:0] count_i,
    input  logic             hit_i,
    output logic             run_o,
    output logic             ien_o,
    output logic             core_sel_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             cur_clr_o
);
    localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_RLD  = AW'(OFS_RLD);
    localparam logic [AW-1:0] A_CUR  = AW'(OFS_CUR);

    logic             run_q, ien_q, core_q, flag_q;
    logic [CNT_W-1:0] reload_q;
    logic [DW-1:0]    rdata_q, rd_mux;
    logic             ctrl_rd;

    assign ctrl_rd   = bus_rd & (bus_addr == A_CTRL);
    assign cur_clr_o = bus_wr & (bus_addr == A_CUR);

    // Control bits are written as a group; other bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            ien_q  <= 1'b0;
            core_q <= 1'b0;
        end else if (bus_wr && bus_addr == A_CTRL) begin
            run_q  <= bus_wdata[BIT_RUN];
            ien_q  <= bus_wdata[BIT_PEND];
            core_q <= bus_wdata[BIT_CORE];
        end
    end

    // Reload value keeps only the counter width.
    always_ff @(posedge clk) begin
        if (!rst_n)                          reload_q <= '0;
        else if (bus_wr && bus_addr == A_RLD) reload_q <= bus_wdata[CNT_W-1:0];
    end

    // Sticky flag: a new wrap beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                    flag_q <= 1'b0;
        else if (hit_i)                flag_q <= 1'b1;
        else if (ctrl_rd || cur_clr_o) flag_q <= 1'b0;
    end

    // Select the addressed register for the read path.
    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            A_CTRL: begin
                rd_mux[BIT_RUN]  = run_q;
                rd_mux[BIT_PEND] = ien_q;
                rd_mux[BIT_CORE] = core_q;
                rd_mux[BIT_FLAG] = flag_q;
            end
            A_RLD:   rd_mux = DW'(reload_q);
            A_CUR:   rd_mux = DW'(count_i);
            default: rd_mux = '0;
        endcase
    end

    // Read data is registered and zero when no read was made.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    assign run_o      = run_q;
    assign ien_o      = ien_q;
    assign core_sel_o = core_q;
    assign reload_o   = reload_q;
    assign bus_rdata  = rdata_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> flag_q); // R7
    AST_FLAG_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && !hit_i) |=> !flag_q); // R8
    AST_CUR_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cur_clr_o |=> !flag_q); // R9
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R12
    AST_RLD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_RLD) |=> (bus_rdata[DW-1:CNT_W] == '0)); // R3
endmodule

// File: rtl/tick_timer.sv
// Top of the periodic tick down-counter: ties register port, source select and counter.
// Assumes CNT_W < DW and that bit 16 of the data word exists (DW > 16).
module tick_timer #(
    parameter int unsigned CNT_W           = 24,
    parameter int unsigned AW              = 8,
    parameter int unsigned DW              = 32,
    parameter int unsigned REF_SYNC_STAGES = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ref_tick,
    output logic          tick_pend
);
    logic             run, ien, core_sel, step, cur_clr, hit;
    logic [CNT_W-1:0] reload, count;

    tick_regs #(.CNT_W(CNT_W), .AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .count_i    (count),
        .hit_i      (hit),
        .run_o      (run),
        .ien_o      (ien),
        .core_sel_o (core_sel),
        .reload_o   (reload),
        .cur_clr_o  (cur_clr)
    );

    tick_src_sel #(.SYNC_STAGES(REF_SYNC_STAGES)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .core_sel_i (core_sel),
        .ref_i      (ref_tick),
        .step_o     (step)
    );

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .clear_i  (cur_clr),
        .ien_i    (ien),
        .reload_i (reload),
        .count_o  (count),
        .hit_o    (hit),
        .pend_o   (tick_pend)
    );

    AST_NO_PEND_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cur_clr |=> !tick_pend); // R9
    AST_PEND_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien) |=> !tick_pend); // R10
endmodule

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
    localparam logic [7:0] A_CTRL = 8'h10;
    localparam logic [7:0] A_RLD  = 8'h14;
    localparam logic [7:0] A_CUR  = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic        bus_wr, bus_rd, ref_tick;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        tick_pend;

    int checks = 0;
    int errors = 0;
    int pend_seen = 0;
    bit chk_on = 1'b0;
    string cur = "R1";

    // reference model state
    bit          m_run, m_ien, m_core, m_flag, m_pend;
    int unsigned m_rld, m_cnt;
    logic [31:0] m_rdata;

    always #2 clk = ~clk;

    tick_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ref_tick(ref_tick), .tick_pend(tick_pend)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_ien = 0; m_core = 0; m_flag = 0; m_pend = 0;
            m_rld = 0; m_cnt = 0; m_rdata = 0;
        end else begin
            bit step, curw, wrap, ctrl_read;
            int unsigned ncnt;
            m_rdata = 0;
            if (bus_rd) begin
                if (bus_addr == A_CTRL)
                    m_rdata = {15'd0, m_flag, 13'd0, m_core, m_ien, m_run};
                else if (bus_addr == A_RLD) m_rdata = m_rld;
                else if (bus_addr == A_CUR) m_rdata = m_cnt;
            end
            curw = bus_wr && bus_addr == A_CUR;
            ctrl_read = bus_rd && bus_addr == A_CTRL;
            step = m_run && (m_core || ref_tick);
            wrap = step && !curw && m_cnt == 1;
            ncnt = m_cnt;
            if (curw) ncnt = 0;
            else if (step) ncnt = (m_cnt == 0) ? m_rld : m_cnt - 1;
            if (wrap) m_flag = 1;
            else if (curw || ctrl_read) m_flag = 0;
            m_pend = wrap && m_ien;
            m_cnt = ncnt;
            if (bus_wr && bus_addr == A_CTRL) begin
                m_run = bus_wdata[0]; m_ien = bus_wdata[1]; m_core = bus_wdata[2];
            end
            if (bus_wr && bus_addr == A_RLD) m_rld = bus_wdata & 32'h00FF_FFFF;
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            check(bus_rdata, m_rdata, {cur, " rdata"});
            check({31'd0, tick_pend}, {31'd0, m_pend}, {cur, " pend"});
        end
        if (tick_pend) pend_seen++;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        check(bus_rdata, e, tag);
    endtask

    task automatic rd(input logic [7:0] a);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
    endtask

    initial begin : watchdog
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; ref_tick = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_on = 1;

        // R1: reset values
        cur = "R1";
        rd_exp(A_CTRL, 32'h0, "R1 ctrl");
        rd_exp(A_RLD, 32'h0, "R1 reload");
        rd_exp(A_CUR, 32'h0, "R1 current");
        check({31'd0, tick_pend}, 32'h0, "R1 pend");

        // R2: control bits read back, others ignored
        cur = "R2";
        wr(A_CTRL, 32'hFFFF_FFF8);
        rd_exp(A_CTRL, 32'h0, "R2 ignored bits");
        wr(A_CTRL, 32'h0000_0005);
        rd_exp(A_CTRL, 32'h0000_0005, "R2 readback");
        wr(A_CTRL, 32'h0);

        // R3: 24-bit fields
        cur = "R3";
        wr(A_RLD, 32'hFFFF_FFFF);
        rd_exp(A_RLD, 32'h00FF_FFFF, "R3 reload width");
        wr(A_CTRL, 32'h5);
        idle(3);
        wr(A_CTRL, 32'h0);
        rd(A_CUR);
        check({24'd0, bus_rdata[31:24]}, 32'h0, "R3 current upper");

        // R4, R6: free running on core clock
        cur = "R4";
        wr(A_RLD, 32'd5);
        wr(A_CUR, 32'h1234);
        wr(A_CTRL, 32'h7);
        idle(20);
        cur = "R6";
        repeat (12) rd(A_CUR);

        // R7, R8: flag after running, cleared by read
        cur = "R7";
        wr(A_RLD, 32'd2);
        idle(10);
        wr(A_CTRL, 32'h6);
        rd_exp(A_CTRL, 32'h0001_0006, "R7 flag set");
        rd_exp(A_CTRL, 32'h0000_0006, "R8 flag cleared");

        // R10: pend with enable, none without
        cur = "R10";
        pend_seen = 0;
        wr(A_CTRL, 32'h7);
        idle(12);
        check({31'd0, pend_seen > 0}, 32'h1, "R10 pend seen");
        wr(A_CTRL, 32'h5);
        @(negedge clk);
        pend_seen = 0;
        idle(12);
        check(pend_seen, 0, "R10 no pend when disabled");

        // R9: writes to current value while running
        cur = "R9";
        wr(A_CTRL, 32'h7);
        idle(6);
        pend_seen = 0;
        bus_wr = 1; bus_addr = A_CUR; bus_wdata = 32'hABCD;
        idle(8);
        bus_addr = A_CTRL; bus_wdata = 32'h6;
        @(negedge clk);
        bus_wr = 0;
        check(pend_seen, 0, "R9 no pend on clear");
        rd_exp(A_CTRL, 32'h0000_0006, "R9 flag cleared");
        rd_exp(A_CUR, 32'd2, "R9 restart from zero");

        // R5: reference strobe source
        cur = "R5";
        wr(A_RLD, 32'd4);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h3);
        for (int i = 0; i < 40; i++) begin
            ref_tick = (i % 3 == 0);
            bus_rd = (i % 2 == 0); bus_addr = A_CUR;
            @(negedge clk);
        end
        ref_tick = 0; bus_rd = 0;
        rd(A_CUR);
        idle(6);
        rd(A_CUR);

        // R8: ctrl read every cycle at reload 1
        cur = "R8";
        wr(A_RLD, 32'd1);
        wr(A_CTRL, 32'h7);
        bus_rd = 1; bus_addr = A_CTRL;
        idle(20);
        bus_rd = 0;
        wr(A_CTRL, 32'h0);
        rd(A_CTRL);

        // R11: reload zero parks the counter
        cur = "R11";
        wr(A_RLD, 32'd0);
        wr(A_CUR, 32'd0);
        wr(A_CTRL, 32'h7);
        @(negedge clk);
        pend_seen = 0;
        idle(20);
        check(pend_seen, 0, "R11 no pend");
        rd_exp(A_CTRL, 32'h0000_0007, "R11 no flag");
        rd_exp(A_CUR, 32'h0, "R11 parked");

        // R12: unmapped offsets and idle read data
        cur = "R12";
        rd_exp(8'h1C, 32'h0, "R12 unmapped");
        rd_exp(8'h00, 32'h0, "R12 unmapped low");
        idle(2);
        check(bus_rdata, 32'h0, "R12 idle zero");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule